// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This block picks one interrupt to present to a processor out of a set of maskable sources and two sources that can never be masked: a non-maskable interrupt and an address-break event. Each maskable source has an enable bit, a one-bit control level and a mode bit. The mode bit selects whether the source is latched on a rising edge or followed as a level. Two mask bits, I and UI, are kept inside the block, and they give three acceptance states. A level-0 source is blocked whenever I is set. A level-1 source is blocked only when I and UI are both set.

The block registers the winning request as a valid flag and a vector index. When the processor acknowledges a presented request, the block clears that request if it was latched. In the same clock edge it sets I and UI, which is what entering an exception requires. Software can load both mask bits through a write strobe. The control-level, enable and mode vectors are supplied by the surrounding register logic.

Top module: `lvl_mask_intc`

## Requirements
- R1: While reset is low, and after it is released with no requests, irqValid is 0 and maskI and maskUI are both 1.
- R2: An enabled, pending source whose level bit is 0 can win only while maskI is 0.
- R3: An enabled, pending source whose level bit is 1 can win while maskI or maskUI is 0, and is blocked when both are 1.
- R4: The non-maskable and address-break requests are accepted whatever maskI and maskUI hold.
- R5: A source whose enable bit is 0 never wins, whatever its request, level or the masks.
- R6: The winner follows this fixed order, from highest to lowest: non-maskable interrupt (index 0), then accepted level-1 sources from the lowest number up, then address break (index 1), then accepted level-0 sources from the lowest number up. Source k is reported as index k+2.
- R7: An ack while irqValid is 1 sets maskI and maskUI to 1 at that clock edge. This takes priority over a mask write in the same cycle.
- R8: An ack while irqValid is 1 clears the pending flag of the presented request if that request is edge-latched. This holds for a source whose mode bit is 1, for the non-maskable request and for the address-break request. A level-mode source (mode bit 0) stays pending for as long as its input is high.
- R9: An ack while irqValid is 0 has no effect on maskI and maskUI.
- R10: A mask write (maskWr high) loads maskI from maskWrI and maskUI from maskWrUI at the clock edge.
- R11: An edge-latched request, including the non-maskable and address-break inputs, becomes pending on a 0-to-1 input transition. It stays pending after the input falls, until it is acknowledged. An input held high does not latch again.
- R12: irqValid and irqIndex are registered. They reflect the requests, configuration and mask bits as updated at the same clock edge that samples the inputs.

Interface notes for R6 and R12: the index is 0 for the non-maskable request, 1 for address break, and k+2 for source k. The outputs change at the edge where the causing input is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcReq | input | NSRC | Request inputs of the maskable sources |
| srcEdge | input | NSRC | Per-source mode: 1 = edge-latched, 0 = level |
| srcEn | input | NSRC | Per-source enable |
| srcLvl | input | NSRC | Per-source control level |
| nmiIn | input | 1 | Non-maskable request (rising edge) |
| brkIn | input | 1 | Address-break request (rising edge) |
| maskWr | input | 1 | Load strobe for the mask bits |
| maskWrI | input | 1 | Value to load into maskI |
| maskWrUI | input | 1 | Value to load into maskUI |
| ack | input | 1 | Acceptance of the presented request |
| irqValid | output | 1 | A request is presented |
| irqIndex | output | IDXW | Vector index of the presented request |
| maskI | output | 1 | Current I mask bit |
| maskUI | output | 1 | Current UI mask bit |

## Verification
The hardest state to reach is one where an ack changes two things at the same edge. The masks tighten while an unmaskable request is still pending underneath, so the presented index must move from a level-1 source to the address break. A further case is an ack that coincides with a software mask write. The stimulus gets there by queuing an address-break pulse and a held level-1 request with the masks open, then acknowledging. A long pseudo-random sweep covers every mask state against mixed patterns of requests, enables and levels. The bench compares each result against an arithmetic model of the acceptance and priority rules.

// File: rtl/lmi_pkg.sv
package lmi_pkg;
  typedef struct packed {
    logic loadMask;
    logic newI;
    logic newUI;
    logic clrNmi;
    logic clrBrk;
  } strobe_t;
endpackage

// File: rtl/lmi_arbiter.sv
module lmi_arbiter #(
  parameter int NSRC = 8,
  parameter int IDXW = $clog2(NSRC + 2)
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] lvl,
  input  logic            nmiPend,
  input  logic            brkPend,
  input  logic            iBit,
  input  logic            uiBit,
  output logic            winValid,
  output logic [IDXW-1:0] winIdx
);
  logic [NSRC-1:0] okLow, okHigh;
  logic            anyLow, anyHigh;
  logic [IDXW-1:0] idxLow, idxHigh;

  assign okLow  = pend & en & ~lvl & {NSRC{~iBit}};
  assign okHigh = pend & en &  lvl & {NSRC{~(iBit & uiBit)}};

  // descending scan: lowest-numbered eligible source ends up selected
  always_comb begin
    anyLow  = 1'b0;
    anyHigh = 1'b0;
    idxLow  = '0;
    idxHigh = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (okLow[k]) begin
        anyLow = 1'b1;
        idxLow = IDXW'(k + 2);
      end
      if (okHigh[k]) begin
        anyHigh = 1'b1;
        idxHigh = IDXW'(k + 2);
      end
    end
  end

  always_comb begin
    winValid = 1'b1;
    if (nmiPend)      winIdx = '0;
    else if (anyHigh) winIdx = idxHigh;
    else if (brkPend) winIdx = IDXW'(1);
    else if (anyLow)  winIdx = idxLow;
    else begin
      winValid = 1'b0;
      winIdx   = '0;
    end
  end
endmodule

// File: rtl/lmi_ctrl.sv
module lmi_ctrl
  import lmi_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int IDXW = $clog2(NSRC + 2)
) (
  input  logic            ack,
  input  logic            irqValid,
  input  logic [IDXW-1:0] irqIndex,
  input  logic            maskWr,
  input  logic            maskWrI,
  input  logic            maskWrUI,
  input  logic [NSRC-1:0] srcEdge,
  output strobe_t         stb,
  output logic [NSRC-1:0] clrSrc
);
  logic take;
  assign take = ack & irqValid;

  always_comb begin
    stb.loadMask = take | maskWr;
    stb.newI     = take | maskWrI;
    stb.newUI    = take | maskWrUI;
    stb.clrNmi   = take && (irqIndex == IDXW'(0));
    stb.clrBrk   = take && (irqIndex == IDXW'(1));
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_clr
    assign clrSrc[k] = take && srcEdge[k] && (irqIndex == IDXW'(k + 2));
  end
endmodule

// File: rtl/lmi_datapath.sv
module lmi_datapath
  import lmi_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int IDXW = $clog2(NSRC + 2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcReq,
  input  logic [NSRC-1:0] srcEdge,
  input  logic            nmiIn,
  input  logic            brkIn,
  input  strobe_t         stb,
  input  logic [NSRC-1:0] clrSrc,
  input  logic            winValid,
  input  logic [IDXW-1:0] winIdx,
  output logic [NSRC-1:0] pendNext,
  output logic            nmiNext,
  output logic            brkNext,
  output logic            iNext,
  output logic            uiNext,
  output logic            irqValid,
  output logic [IDXW-1:0] irqIndex,
  output logic            maskI,
  output logic            maskUI
);
  logic [NSRC-1:0] reqQ, edgePend, edgeNext;
  logic            nmiQ, brkQ, nmiPend, brkPend;

  assign edgeNext = (edgePend & ~clrSrc) | (srcReq & ~reqQ);
  assign pendNext = (srcEdge & edgeNext) | (~srcEdge & srcReq);
  assign nmiNext  = (nmiPend & ~stb.clrNmi) | (nmiIn & ~nmiQ);
  assign brkNext  = (brkPend & ~stb.clrBrk) | (brkIn & ~brkQ);
  assign iNext    = stb.loadMask ? stb.newI  : maskI;
  assign uiNext   = stb.loadMask ? stb.newUI : maskUI;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ     <= '0;
      edgePend <= '0;
      nmiQ     <= 1'b0;
      brkQ     <= 1'b0;
      nmiPend  <= 1'b0;
      brkPend  <= 1'b0;
      maskI    <= 1'b1;
      maskUI   <= 1'b1;
      irqValid <= 1'b0;
      irqIndex <= '0;
    end else begin
      reqQ     <= srcReq;
      edgePend <= edgeNext & srcEdge;
      nmiQ     <= nmiIn;
      brkQ     <= brkIn;
      nmiPend  <= nmiNext;
      brkPend  <= brkNext;
      maskI    <= iNext;
      maskUI   <= uiNext;
      irqValid <= winValid;
      irqIndex <= winIdx;
    end
  end

  // R4: a latched non-maskable request is always the one presented
  p_nmi_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    nmiPend |-> (irqValid && irqIndex == IDXW'(0)));

  // R11: latched unmaskable requests persist until acknowledged
  p_nmi_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && !stb.clrNmi) |=> nmiPend);
  p_brk_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (brkPend && !stb.clrBrk) |=> brkPend);
endmodule

// File: rtl/lvl_mask_intc.sv
module lvl_mask_intc
  import lmi_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int IDXW = $clog2(NSRC + 2),
  localparam int SRCW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcReq,
  input  logic [NSRC-1:0] srcEdge,
  input  logic [NSRC-1:0] srcEn,
  input  logic [NSRC-1:0] srcLvl,
  input  logic            nmiIn,
  input  logic            brkIn,
  input  logic            maskWr,
  input  logic            maskWrI,
  input  logic            maskWrUI,
  input  logic            ack,
  output logic            irqValid,
  output logic [IDXW-1:0] irqIndex,
  output logic            maskI,
  output logic            maskUI
);
  strobe_t         stb;
  logic [NSRC-1:0] clrSrc, pendNext;
  logic            nmiNext, brkNext, iNext, uiNext, winValid;
  logic [IDXW-1:0] winIdx;
  logic [SRCW-1:0] winSrc;

  lmi_ctrl #(.NSRC(NSRC), .IDXW(IDXW)) u_ctrl (
    .ack(ack), .irqValid(irqValid), .irqIndex(irqIndex),
    .maskWr(maskWr), .maskWrI(maskWrI), .maskWrUI(maskWrUI),
    .srcEdge(srcEdge), .stb(stb), .clrSrc(clrSrc));

  lmi_datapath #(.NSRC(NSRC), .IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEdge(srcEdge),
    .nmiIn(nmiIn), .brkIn(brkIn), .stb(stb), .clrSrc(clrSrc),
    .winValid(winValid), .winIdx(winIdx), .pendNext(pendNext),
    .nmiNext(nmiNext), .brkNext(brkNext), .iNext(iNext), .uiNext(uiNext),
    .irqValid(irqValid), .irqIndex(irqIndex), .maskI(maskI), .maskUI(maskUI));

  lmi_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
    .pend(pendNext), .en(srcEn), .lvl(srcLvl), .nmiPend(nmiNext),
    .brkPend(brkNext), .iBit(iNext), .uiBit(uiNext),
    .winValid(winValid), .winIdx(winIdx));

  assign winSrc = SRCW'(winIdx - IDXW'(2));

  // R2: a level-0 winner only under an open I bit
  p_lvl0_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winIdx >= IDXW'(2) && !srcLvl[winSrc]) |-> !iNext);
  // R3: a level-1 winner never with both mask bits set
  p_lvl1_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winIdx >= IDXW'(2) && srcLvl[winSrc]) |-> !(iNext && uiNext));
  // R5: disabled sources never win
  p_enabled_win_r5: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winIdx >= IDXW'(2)) |-> srcEn[winSrc]);
  // R7: acceptance closes both masks
  p_ack_masks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqValid) |=> (maskI && maskUI));
  // R9: an ack with nothing presented leaves the masks alone
  p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !irqValid && !maskWr) |=> ($stable(maskI) && $stable(maskUI)));
endmodule

// File: tb/lvl_mask_intc_test.sv
module lvl_mask_intc_test;
  localparam int N = 8;
  localparam int IW = $clog2(N + 2);

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] srcReq = '0, srcEdge = '0, srcEn = '0, srcLvl = '0;
  logic nmiIn = 0, brkIn = 0, maskWr = 0, maskWrI = 0, maskWrUI = 0, ack = 0;
  logic irqValid, maskI, maskUI;
  logic [IW-1:0] irqIndex;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  lvl_mask_intc #(.NSRC(N)) uut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEdge(srcEdge), .srcEn(srcEn),
    .srcLvl(srcLvl), .nmiIn(nmiIn), .brkIn(brkIn), .maskWr(maskWr),
    .maskWrI(maskWrI), .maskWrUI(maskWrUI), .ack(ack), .irqValid(irqValid),
    .irqIndex(irqIndex), .maskI(maskI), .maskUI(maskUI));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setMask(logic i, logic ui);
    maskWr = 1; maskWrI = i; maskWrUI = ui;
    tick();
    maskWr = 0;
  endtask

  // arithmetic model of acceptance and priority (level sources, no unmaskables)
  function automatic int model(logic [N-1:0] rq, logic [N-1:0] en, logic [N-1:0] lv,
                               logic i, logic ui);
    for (int k = 0; k < N; k++)
      if (rq[k] && en[k] && lv[k] && !(i && ui)) return k + 2;
    for (int k = 0; k < N; k++)
      if (rq[k] && en[k] && !lv[k] && !i) return k + 2;
    return -1;
  endfunction

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    int e;
    #1;
    tick(); tick();
    chk("R1 valid in reset", irqValid, 0);
    chk("R1 maskI in reset", maskI, 1);
    chk("R1 maskUI in reset", maskUI, 1);
    rstN = 1;
    tick();
    chk("R1 valid after reset", irqValid, 0);
    chk("R1 masks after reset", {maskI, maskUI}, 3);

    // sweep R2 R3 R5 R6 R10 R12 over all mask states, level-mode sources
    lf = 32'h1F2E3D4C;
    for (int t = 0; t < 1600; t++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      srcReq = lf[7:0]; srcEn = lf[15:8] | lf[31:24]; srcLvl = lf[23:16];
      setMask(t[1], t[0]);
      chk("R10 mask load", {maskI, maskUI}, t & 3);
      e = model(srcReq, srcEn, srcLvl, t[1], t[0]);
      chk("R2/R3/R5 valid", irqValid, (e >= 0) ? 1 : 0);
      if (e >= 0) chk("R6 index", irqIndex, e);
    end
    srcReq = '0; tick();

    // R11 R8 edge latching and clearing
    srcEdge = '1; srcEn = '1; srcLvl = '0;
    setMask(0, 0);
    chk("R12 idle", irqValid, 0);
    srcReq[5] = 1; tick();
    chk("R12 edge seen same edge", irqValid, 1);
    chk("R11 index", irqIndex, 7);
    srcReq[5] = 0; tick(); tick();
    chk("R11 held after drop", irqIndex, 7);
    chk("R11 valid after drop", irqValid, 1);
    ack = 1; tick(); ack = 0;
    chk("R7 masks closed", {maskI, maskUI}, 3);
    chk("R2 blocked by I", irqValid, 0);
    setMask(0, 0);
    chk("R8 edge cleared", irqValid, 0);

    // R8 level source survives ack; R3
    srcEdge[4] = 0; srcLvl[4] = 1; srcReq[4] = 1; tick();
    chk("R3 level1 open", irqIndex, 6);
    ack = 1; tick(); ack = 0;
    chk("R3 blocked by I and UI", irqValid, 0);
    setMask(1, 0);
    chk("R8 level kept", irqIndex, 6);
    chk("R3 accepted with UI=0", irqValid, 1);

    // R7 ack beats a write
    ack = 1; maskWr = 1; maskWrI = 0; maskWrUI = 0; tick();
    ack = 0; maskWr = 0;
    chk("R7 ack over write", {maskI, maskUI}, 3);
    srcReq = '0; tick();

    // R9 ack with nothing presented
    setMask(0, 0);
    chk("R9 idle", irqValid, 0);
    ack = 1; tick(); ack = 0;
    chk("R9 masks untouched", {maskI, maskUI}, 0);

    // R4 R6 R11 unmaskables under closed masks
    setMask(1, 1);
    nmiIn = 1; tick();
    chk("R4 nmi accepted", irqValid, 1);
    chk("R4 nmi index", irqIndex, 0);
    brkIn = 1; tick();
    chk("R6 nmi over break", irqIndex, 0);
    ack = 1; tick(); ack = 0;
    chk("R4 break accepted", irqIndex, 1);
    chk("R8 nmi cleared", irqValid, 1);
    ack = 1; tick(); ack = 0;
    chk("R11 held input no relatch", irqValid, 0);
    nmiIn = 0; brkIn = 0; tick();

    // R6 break between levels; ack retargets to break
    srcEdge = '0; setMask(0, 0);
    srcReq[6] = 1; tick();
    chk("R6 level0 alone", irqIndex, 8);
    brkIn = 1; tick(); brkIn = 0;
    chk("R6 break over level0", irqIndex, 1);
    srcLvl[2] = 1; srcReq[2] = 1; tick();
    chk("R6 level1 over break", irqIndex, 4);
    ack = 1; tick(); ack = 0;
    chk("R7 masks closed again", {maskI, maskUI}, 3);
    chk("R4 break after ack", irqIndex, 1);
    ack = 1; tick(); ack = 0;
    chk("R8 break cleared", irqValid, 0);

    // R5 disabled level1 source with open masks
    setMask(0, 0);
    srcEn = 8'h00; tick();
    chk("R5 all disabled", irqValid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule